// File: doc/BRIEF.md
# Timed Three-Color Lamp Switch Controller

This block decides which color a lamp lights each time its single on/off wall switch is closed. The lamp carries two white LED strings and two yellow LED strings and can show three lit colors: white, daylight (white and yellow together) and yellow. Flicking the switch off and quickly back on steps the lamp from white to daylight to yellow and back to white. Leaving the switch open longer than a threshold of 1 s always brings the lamp back to white on the next close.

The switch arrives as an already debounced level sampled on the system clock: high means closed, low means open. While the switch is open every string is dark and a saturating counter measures the open time in clock cycles. On each close (a low-to-high change of the sampled level) the new color is chosen from the remembered color and the measured open time, and the strings are lit in the following cycle. A 2-bit color code is provided for observation. The threshold is derived from the clock frequency and a millisecond parameter.

Top module: `tricolor_lamp_ctrl`

## Requirements
- R1: While reset is held and after it, until the first close, all string enables are 0 and the color code is 2'b00 (dark).
- R2: After reset the remembered color is white and the open timer reads expired, so the first close lights white.
- R3: When the lamp was white and the switch closes after an open time shorter than the threshold, the lamp lights daylight.
- R4: When the lamp was daylight and the switch closes after an open time shorter than the threshold, the lamp lights yellow.
- R5: When the lamp was yellow, the next close lights white, even after a short open time.
- R6: An open time of at least the threshold (the timer saturates there, so any longer time also counts) makes the next close light white whatever the previous color.
- R7: The open time is the number of rising clock edges at which the switch is sampled low since the last high sample; exactly threshold-1 counts as short, exactly threshold counts as expired.
- R8: Color code 2'b01 is white with both white enables 1 and both yellow enables 0; 2'b10 is daylight with all four enables 1; 2'b11 is yellow with both yellow enables 1 and both white enables 0; 2'b00 is dark with all enables 0.
- R9: One cycle after the switch is sampled low, all enables are 0 and the code is 2'b00, and they stay so while the switch stays open.
- R10: The new color appears in the cycle after the clock edge that samples the close; while the switch stays closed the color does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_closed | input | 1 | Debounced switch level, 1 = closed |
| white_en | output | STRINGS | Enable per white LED string (default 2) |
| yellow_en | output | STRINGS | Enable per yellow LED string (default 2) |
| color_code | output | 2 | 00 dark, 01 white, 10 daylight, 11 yellow |

## Verification
Directed sequences walk the full white, daylight, yellow, white cycle with short opens, which tells the stepping rule apart from a plain reset-to-white rule. Opens of exactly threshold-1 and exactly threshold cycles separate the short and expired cases at the boundary, and an open of three thresholds shows the timer saturating instead of wrapping back to short. A seeded random run mixes closed stretches with open stretches biased toward the boundary, checked every cycle against a bench model, to catch ordering slips between the open-edge darkening and the close-edge color choice.

// File: rtl/lamp_pkg.sv
// Package: shared color encoding for the three-color lamp controller.
// Assumes a 2-bit code where 0 means dark and is never stored as a color.
package lamp_pkg;

    typedef enum logic [1:0] {
        LC_DARK   = 2'd0,
        LC_WHITE  = 2'd1,
        LC_DAY    = 2'd2,
        LC_YELLOW = 2'd3
    } lamp_color_e;

    // Short-open successor of a lit color.
    function automatic lamp_color_e step_color(input lamp_color_e cur);
        case (cur)
            LC_WHITE: step_color = LC_DAY;
            LC_DAY:   step_color = LC_YELLOW;
            default:  step_color = LC_WHITE;
        endcase
    endfunction

endpackage

// File: rtl/open_timer.sv
// Module: open_timer
// Counts clock edges at which the switch is sampled open, saturating at
// LIMIT. Reads expired once the count reaches LIMIT. Assumes the switch
// level is already debounced and synchronous to clk.
module open_timer #(
    parameter int unsigned LIMIT = 50_000_000,
    localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_closed,
    output logic expired
);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] open_cnt;

    // Open-time counter: cleared while closed, saturating count while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_cnt <= LIMIT_V;
        end else if (sw_closed) begin
            open_cnt <= '0;
        end else if (open_cnt != LIMIT_V) begin
            open_cnt <= open_cnt + 1'b1;
        end
    end

    assign expired = (open_cnt == LIMIT_V);

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        open_cnt <= LIMIT_V); // R6

    AST_EXPIRED_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !sw_closed) |=> expired); // R6

endmodule

// File: rtl/color_tracker.sv
// Module: color_tracker
// Remembers the last lit color and whether the lamp is lit. On a close
// edge it chooses the next color from the open timer; on any open sample
// it darkens the lamp. Assumes close_edge is a one-cycle pulse.
module color_tracker
    import lamp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_closed,
    input  logic        close_edge,
    input  logic        expired,
    output lamp_color_e cur_color,
    output logic        lit
);
    lamp_color_e next_color;

    // Next-color choice made at the close edge.
    always_comb begin
        next_color = expired ? LC_WHITE : step_color(cur_color);
    end

    // Remembered color and lit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_color <= LC_WHITE;
            lit       <= 1'b0;
        end else if (!sw_closed) begin
            lit       <= 1'b0;
        end else if (close_edge) begin
            cur_color <= next_color;
            lit       <= 1'b1;
        end
    end

    AST_YELLOW_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (close_edge && cur_color == LC_YELLOW) |=> cur_color == LC_WHITE); // R5

    AST_NEVER_DARK_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
        cur_color != LC_DARK); // R8

endmodule

// File: rtl/string_driver.sv
// Module: string_driver
// Decodes the lit color into per-string enables and an observation code.
// Assumes the color input is never dark while lit is set.
module string_driver
    import lamp_pkg::*;
#(
    parameter int unsigned STRINGS = 2
) (
    input  lamp_color_e        color,
    input  logic               lit,
    output logic [STRINGS-1:0] white_en,
    output logic [STRINGS-1:0] yellow_en,
    output logic [1:0]         color_code
);
    logic white_on;
    logic yellow_on;

    // Which color groups the lit color uses.
    always_comb begin
        white_on  = lit && (color == LC_WHITE  || color == LC_DAY);
        yellow_on = lit && (color == LC_YELLOW || color == LC_DAY);
        color_code = lit ? color : LC_DARK;
    end

    for (genvar g = 0; g < STRINGS; g++) begin : g_lane
        assign white_en[g]  = white_on;
        assign yellow_en[g] = yellow_on;
    end

endmodule

// File: rtl/tricolor_lamp_ctrl.sv
// Module: tricolor_lamp_ctrl (top)
// Picks the lamp color on each switch close from the previous color and
// the open time, threshold OPEN_MS milliseconds at CLK_HZ. Assumes a
// debounced, clk-synchronous switch level and synchronous active-low reset.
module tricolor_lamp_ctrl
    import lamp_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned OPEN_MS = 1000,
    parameter int unsigned STRINGS = 2,
    localparam int unsigned LIMIT  = (CLK_HZ / 1000) * OPEN_MS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_closed,
    output logic [STRINGS-1:0] white_en,
    output logic [STRINGS-1:0] yellow_en,
    output logic [1:0]         color_code
);
    logic        sw_prev;
    logic        close_edge;
    logic        expired;
    logic        lit;
    lamp_color_e cur_color;

    // Previous switch sample for close-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_prev <= 1'b0;
        else        sw_prev <= sw_closed;
    end

    assign close_edge = sw_closed && !sw_prev;

    open_timer #(.LIMIT(LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_closed (sw_closed),
        .expired   (expired)
    );

    color_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_closed  (sw_closed),
        .close_edge (close_edge),
        .expired    (expired),
        .cur_color  (cur_color),
        .lit        (lit)
    );

    string_driver #(.STRINGS(STRINGS)) u_drv (
        .color      (cur_color),
        .lit        (lit),
        .white_en   (white_en),
        .yellow_en  (yellow_en),
        .color_code (color_code)
    );

    AST_DARK_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_closed |=> (color_code == 2'b00 && white_en == '0 && yellow_en == '0)); // R9

    AST_LONG_OPEN_WHITE: assert property (@(posedge clk) disable iff (!rst_n)
        (close_edge && expired) |=> color_code == 2'b01); // R6

    AST_HOLD_WHILE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_closed && sw_prev) |=> $stable(color_code)); // R10

    AST_DAY_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        color_code == 2'b10 |-> (&white_en && &yellow_en)); // R8

endmodule

// File: tb/test_tricolor_lamp_ctrl.sv
module test_tricolor_lamp_ctrl;
    localparam int CLK_HZ  = 100_000;
    localparam int OPEN_MS = 1;
    localparam int LIM     = 100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sw_closed;
    logic [1:0] white_en;
    logic [1:0] yellow_en;
    logic [1:0] color_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    int m_cnt;
    int m_color;
    bit m_lit;
    bit m_prev;

    tricolor_lamp_ctrl #(.CLK_HZ(CLK_HZ), .OPEN_MS(OPEN_MS), .STRINGS(2)) i_tricolor_lamp_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_closed(sw_closed),
        .white_en(white_en), .yellow_en(yellow_en), .color_code(color_code)
    );

    always #10 clk = ~clk;

    function automatic logic [5:0] outs_for(input int code);
        case (code)
            1:       outs_for = {2'b01, 2'b11, 2'b00};
            2:       outs_for = {2'b10, 2'b11, 2'b11};
            3:       outs_for = {2'b11, 2'b00, 2'b11};
            default: outs_for = 6'b0;
        endcase
    endfunction

    function automatic int successor(input int c, input int open_cycles);
        if (open_cycles >= LIM) successor = 1;
        else if (c == 1)        successor = 2;
        else if (c == 2)        successor = 3;
        else                    successor = 1;
    endfunction

    task automatic check_code(input string tag, input int exp_code);
        logic [5:0] act, exp;
        act = {color_code, white_en, yellow_en};
        exp = outs_for(exp_code);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual code/white/yellow=%b expected=%b", tag, act, exp);
        end
    endtask

    // One clock: drive level, update model, sample at the falling edge.
    task automatic tick(input bit lvl, input string tag);
        sw_closed = lvl;
        @(posedge clk);
        if (lvl) begin
            if (!m_prev) begin
                m_color = successor(m_color, m_cnt);
                m_lit = 1'b1;
            end
            m_cnt = 0;
        end else begin
            m_lit = 1'b0;
            if (m_cnt < LIM) m_cnt++;
        end
        m_prev = lvl;
        @(negedge clk);
        check_code(tag, m_lit ? m_color : 0);
    endtask

    task automatic hold(input bit lvl, input int n, input string tag);
        for (int i = 0; i < n; i++) tick(lvl, tag);
    endtask

    task automatic open_then_close(input int n, input string tag, input int exp_code);
        hold(1'b0, n, "R9 dark while open");
        tick(1'b1, tag);
        check_code(tag, exp_code);
    endtask

    initial begin
        int rnd;
        rnd = $urandom(32'h5eed);
        rst_n = 1'b0;
        sw_closed = 1'b0;
        m_cnt = LIM; m_color = 1; m_lit = 1'b0; m_prev = 1'b0;
        repeat (3) @(negedge clk);
        check_code("R1 reset dark", 0);
        rst_n = 1'b1;
        hold(1'b0, 4, "R1 dark before first close");
        tick(1'b1, "R2 first close");
        check_code("R2 first close white", 1);
        hold(1'b1, 5, "R10 stable while closed");
        check_code("R10 still white", 1);
        open_then_close(5, "R3 white short open", 2);
        check_code("R8 daylight all strings", 2);
        open_then_close(5, "R4 daylight short open", 3);
        open_then_close(3, "R5 yellow short open", 1);
        open_then_close(1, "R3 one-cycle open", 2);
        open_then_close(LIM - 1, "R7 threshold-1 is short", 3);
        open_then_close(LIM, "R7 threshold is expired", 1);
        open_then_close(LIM - 1, "R7 short again", 2);
        open_then_close(LIM, "R6 daylight expired", 1);
        open_then_close(2, "R3 step", 2);
        open_then_close(2, "R4 step", 3);
        open_then_close(3 * LIM, "R6 saturated long open", 1);
        tick(1'b0, "R9 dark next cycle");
        check_code("R9 dark after one open sample", 0);
        tick(1'b1, "R10 color after close edge");
        for (int s = 0; s < 250; s++) begin
            int sel, n;
            hold(1'b1, 1 + ($urandom % 4), "R10 random closed");
            sel = $urandom % 6;
            case (sel)
                0: n = LIM - 1;
                1: n = LIM;
                2: n = LIM + 1;
                3: n = 2 * LIM;
                default: n = 1 + ($urandom % 20);
            endcase
            hold(1'b0, n, "R9 random open");
            tick(1'b1, "R6 R3 R4 R5 random close");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule